// File: doc/BRIEF.md
# Debug Test Bus Selector

This block chooses which internal monitor view reaches an 8-bit debug output bus and a companion test-clock pin. A host writes an 8-bit view address. Each address picks a data byte and the strobe that belongs to it. For example, one view shows the receive acquisition progress flags with the initial-detect strobe as its clock. Another shows the RSSI sample with the RSSI converter clock. A logic analyser on the pins can then capture the byte on the matching strobe.

The address is held as a decoded view state. The states are VIEW_QUIET, VIEW_RX_ACQ, VIEW_TX_FIELD, VIEW_RSSI, VIEW_SQ1, VIEW_SQ2, VIEW_CORR, VIEW_FREQ, VIEW_PHASE and VIEW_NCO. There are two kinds of transition:
- A cycle with a write moves from any state to the state decoded from the written value. Unknown values go to VIEW_QUIET.
- A cycle without a write stays in the current state.

The RSSI view also carries a carrier-sense-early bit that is captured on each rising edge of the RSSI conversion pulse. The data byte and the test clock both leave through registers on the system clock, so they stay aligned with each other.

Top module: `dbg_tbus_sel`

## Requirements
- R1: While reset is asserted and at the first check after it, `test_bus` and `test_clk` are 0 and the selected view is the quiet view (address 00h).
- R2: Address 00h drives `test_bus` = 00h and `test_clk` = 0 whatever the monitor inputs do.
- R3: Address 01h drives {`adc_fullscale`, `rx_flags[6:0]`} on bits 7..0, with `init_det` as the test clock.
- R4: Address 02h drives {`adc_fullscale`, `tx_flags[6:0]`} on bits 7..0, with `iq_mark` as the test clock.
- R5: Address 03h drives the latched carrier-sense-early bit on bit 7, `cse_live` on bit 6 and `rssi_val[5:0]` on bits 5..0, with `rssi_adclk` as the test clock.
- R6: Address 04h drives `sq1_word` with `sq1_strobe` as the test clock. Address 05h drives `sq2_word` with `sq2_strobe` as the test clock.
- R7: Address 06h drives `corr_mag` with `corr_sclk` as the test clock.
- R8: Addresses 07h, 08h and 09h drive `freq_reg[18:11]`, `phase_reg[7:0]` and `nco_reg[15:8]` respectively. `sym_clk` is the test clock for all three.
- R9: Any address from 0Ah to FFh behaves as the quiet view: all outputs are 0.
- R10: The latched carrier-sense-early bit takes the value of `cse_live` at a system-clock edge where `rssi_pulse` is 1 and was 0 at the previous edge. It holds at every other edge, and it resets to 0.
- R11: A write with `addr_we`=1 at edge k changes the view used at edge k+1. The outputs after edge n show the inputs sampled at edge n, so the data byte and the test clock share one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | View-address write enable |
| addr_wdata | input | 8 | View address to write |
| adc_fullscale | input | 1 | A/D full-scale calibration flag (bit 7 of the RX and TX views) |
| rx_flags | input | 7 | Carrier sense, energy detect, tracking, SFD detect, signal ready, length ready, header CRC valid (bit 6 down to 0) |
| tx_flags | input | 7 | Delayed TX enable, preamble, SFD, signal, length, header CRC, MPDU start (bit 6 down to 0) |
| init_det | input | 1 | Initial-detect strobe |
| iq_mark | input | 1 | I/Q symbol-boundary mark |
| cse_live | input | 1 | Live carrier-sense-early bit |
| rssi_val | input | 6 | RSSI sample, straight binary |
| rssi_pulse | input | 1 | RSSI conversion pulse |
| rssi_adclk | input | 1 | RSSI converter clock |
| sq1_word | input | 8 | Signal-quality word 1 |
| sq1_strobe | input | 1 | Pulse after quality word 1 is valid |
| sq2_word | input | 8 | Signal-quality word 2 |
| sq2_strobe | input | 1 | Pulse after quality word 2 is valid |
| corr_mag | input | 8 | Low-rate correlator magnitude |
| corr_sclk | input | 1 | Correlator sample clock |
| freq_reg | input | 19 | Frequency register |
| phase_reg | input | 8 | Phase register |
| nco_reg | input | 16 | NCO register |
| sym_clk | input | 1 | Symbol-rate subsample clock |
| test_bus | output | 8 | Registered debug data byte |
| test_clk | output | 1 | Registered test-clock pin |

## Verification
Two things can meet on one edge: the view address is rewritten, and a rising RSSI pulse captures a new carrier-sense-early value. Random write timing and a pulse that is high about a quarter of the time make this happen often, including writes into and out of the RSSI view on the edge of a capture. The bench's behavioural model is judged on every cycle. It uses the old view and the old latched bit for the byte produced at that edge, and the new values from the next edge on. The cycle right after a write is reported under R11, and bit 7 of the RSSI view is reported separately under R10.

// File: rtl/dbg_tbus_pkg.sv
package dbg_tbus_pkg;

    localparam int unsigned BUS_W  = 8;
    localparam int unsigned FLAG_W = BUS_W - 1;
    localparam int unsigned RSSI_W = BUS_W - 2;

    typedef enum logic [3:0] {
        VIEW_QUIET    = 4'd0,
        VIEW_RX_ACQ   = 4'd1,
        VIEW_TX_FIELD = 4'd2,
        VIEW_RSSI     = 4'd3,
        VIEW_SQ1      = 4'd4,
        VIEW_SQ2      = 4'd5,
        VIEW_CORR     = 4'd6,
        VIEW_FREQ     = 4'd7,
        VIEW_PHASE    = 4'd8,
        VIEW_NCO      = 4'd9
    } view_e;

    // Map a host address onto a view; every undefined code is quiet.
    function automatic view_e decode_addr(input logic [BUS_W-1:0] a);
        view_e v;
        unique case (a)
            8'h01:   v = VIEW_RX_ACQ;
            8'h02:   v = VIEW_TX_FIELD;
            8'h03:   v = VIEW_RSSI;
            8'h04:   v = VIEW_SQ1;
            8'h05:   v = VIEW_SQ2;
            8'h06:   v = VIEW_CORR;
            8'h07:   v = VIEW_FREQ;
            8'h08:   v = VIEW_PHASE;
            8'h09:   v = VIEW_NCO;
            default: v = VIEW_QUIET;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dbg_tbus_view_fsm.sv
module dbg_tbus_view_fsm
    import dbg_tbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_addr,
    output view_e            view
);

    view_e state_q;
    view_e state_d;

    // Next-state logic: a write jumps to the decoded view, otherwise hold.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d = decode_addr(wr_addr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VIEW_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    assign view = state_q;

    // Out-of-range addresses must land in the quiet view.
    assert_bad_addr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > 8'h09)) |=> (state_q == VIEW_QUIET));

    // Without a write the selected view never moves.
    assert_view_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));

endmodule

// File: rtl/dbg_tbus_cse_latch.sv
module dbg_tbus_cse_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic cse_in,
    output logic cse_held
);

    logic pulse_d;
    logic rise;

    assign rise = pulse & ~pulse_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_d  <= 1'b0;
            cse_held <= 1'b0;
        end else begin
            pulse_d <= pulse;
            if (rise) begin
                cse_held <= cse_in;
            end
        end
    end

    // Between pulse rises the captured bit keeps its value.
    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pulse) |=> $stable(cse_held));

    // A rise captures the carrier-sense-early level seen at that edge.
    assert_latch_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |=> (cse_held == $past(cse_in)));

endmodule

// File: rtl/dbg_tbus_pack.sv
module dbg_tbus_pack
    import dbg_tbus_pkg::*;
#(
    parameter int unsigned FREQ_W  = 19,
    parameter int unsigned PHASE_W = 8,
    parameter int unsigned NCO_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  view_e              view,
    input  logic               adc_fullscale,
    input  logic [FLAG_W-1:0]  rx_flags,
    input  logic [FLAG_W-1:0]  tx_flags,
    input  logic               init_det,
    input  logic               iq_mark,
    input  logic               cse_held,
    input  logic               cse_live,
    input  logic [RSSI_W-1:0]  rssi_val,
    input  logic               rssi_adclk,
    input  logic [BUS_W-1:0]   sq1_word,
    input  logic               sq1_strobe,
    input  logic [BUS_W-1:0]   sq2_word,
    input  logic               sq2_strobe,
    input  logic [BUS_W-1:0]   corr_mag,
    input  logic               corr_sclk,
    input  logic [FREQ_W-1:0]  freq_reg,
    input  logic [PHASE_W-1:0] phase_reg,
    input  logic [NCO_W-1:0]   nco_reg,
    input  logic               sym_clk,
    output logic [BUS_W-1:0]   test_bus,
    output logic               test_clk
);

    localparam int unsigned FREQ_HI  = FREQ_W - 1;
    localparam int unsigned NCO_HI   = NCO_W - 1;
    localparam int unsigned PHASE_HI = BUS_W - 1;

    logic [BUS_W-1:0] bus_d;
    logic             clk_d;

    // Per-view packing of the data byte and choice of strobe.
    always_comb begin
        bus_d = '0;
        clk_d = 1'b0;
        unique case (view)
            VIEW_QUIET: begin
                bus_d = '0;
                clk_d = 1'b0;
            end
            VIEW_RX_ACQ: begin
                bus_d = {adc_fullscale, rx_flags};
                clk_d = init_det;
            end
            VIEW_TX_FIELD: begin
                bus_d = {adc_fullscale, tx_flags};
                clk_d = iq_mark;
            end
            VIEW_RSSI: begin
                bus_d = {cse_held, cse_live, rssi_val};
                clk_d = rssi_adclk;
            end
            VIEW_SQ1: begin
                bus_d = sq1_word;
                clk_d = sq1_strobe;
            end
            VIEW_SQ2: begin
                bus_d = sq2_word;
                clk_d = sq2_strobe;
            end
            VIEW_CORR: begin
                bus_d = corr_mag;
                clk_d = corr_sclk;
            end
            VIEW_FREQ: begin
                bus_d = freq_reg[FREQ_HI -: BUS_W];
                clk_d = sym_clk;
            end
            VIEW_PHASE: begin
                bus_d = phase_reg[PHASE_HI:0];
                clk_d = sym_clk;
            end
            VIEW_NCO: begin
                bus_d = nco_reg[NCO_HI -: BUS_W];
                clk_d = sym_clk;
            end
            default: begin
                bus_d = '0;
                clk_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_bus <= '0;
            test_clk <= 1'b0;
        end else begin
            test_bus <= bus_d;
            test_clk <= clk_d;
        end
    end

    // The quiet view produces an all-zero bus and a low test clock.
    assert_quiet_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (view == VIEW_QUIET) |=> ((test_bus == '0) && !test_clk));

    // The RSSI view carries the latched bit and the sample one edge later.
    assert_rssi_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (view == VIEW_RSSI) |=> ((test_bus[BUS_W-1] == $past(cse_held)) &&
                                 (test_bus[RSSI_W-1:0] == $past(rssi_val))));

    // All three register views share the symbol clock.
    assert_symclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((view == VIEW_FREQ) || (view == VIEW_PHASE) || (view == VIEW_NCO))
        |=> (test_clk == $past(sym_clk)));

endmodule

// File: rtl/dbg_tbus_sel.sv
module dbg_tbus_sel
    import dbg_tbus_pkg::*;
#(
    parameter int unsigned FREQ_W  = 19,
    parameter int unsigned PHASE_W = 8,
    parameter int unsigned NCO_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_we,
    input  logic [7:0]         addr_wdata,
    input  logic               adc_fullscale,
    input  logic [6:0]         rx_flags,
    input  logic [6:0]         tx_flags,
    input  logic               init_det,
    input  logic               iq_mark,
    input  logic               cse_live,
    input  logic [5:0]         rssi_val,
    input  logic               rssi_pulse,
    input  logic               rssi_adclk,
    input  logic [7:0]         sq1_word,
    input  logic               sq1_strobe,
    input  logic [7:0]         sq2_word,
    input  logic               sq2_strobe,
    input  logic [7:0]         corr_mag,
    input  logic               corr_sclk,
    input  logic [FREQ_W-1:0]  freq_reg,
    input  logic [PHASE_W-1:0] phase_reg,
    input  logic [NCO_W-1:0]   nco_reg,
    input  logic               sym_clk,
    output logic [7:0]         test_bus,
    output logic               test_clk
);

    view_e view;
    logic  cse_held;

    dbg_tbus_view_fsm u_view (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_we),
        .wr_addr (addr_wdata),
        .view    (view)
    );

    dbg_tbus_cse_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (rssi_pulse),
        .cse_in   (cse_live),
        .cse_held (cse_held)
    );

    dbg_tbus_pack #(
        .FREQ_W  (FREQ_W),
        .PHASE_W (PHASE_W),
        .NCO_W   (NCO_W)
    ) u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .view          (view),
        .adc_fullscale (adc_fullscale),
        .rx_flags      (rx_flags),
        .tx_flags      (tx_flags),
        .init_det      (init_det),
        .iq_mark       (iq_mark),
        .cse_held      (cse_held),
        .cse_live      (cse_live),
        .rssi_val      (rssi_val),
        .rssi_adclk    (rssi_adclk),
        .sq1_word      (sq1_word),
        .sq1_strobe    (sq1_strobe),
        .sq2_word      (sq2_word),
        .sq2_strobe    (sq2_strobe),
        .corr_mag      (corr_mag),
        .corr_sclk     (corr_sclk),
        .freq_reg      (freq_reg),
        .phase_reg     (phase_reg),
        .nco_reg       (nco_reg),
        .sym_clk       (sym_clk),
        .test_bus      (test_bus),
        .test_clk      (test_clk)
    );

    // A write of 01h shows the receive flags one edge after the next edge.
    assert_write_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && (addr_wdata == 8'h01)) |=> ##1 (test_bus[6:0] == $past(rx_flags)));

endmodule

// File: tb/dbg_tbus_sel_tb.sv
module dbg_tbus_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_we = 1'b0;
    logic [7:0]  addr_wdata = '0;
    logic        adc_fullscale = 1'b0;
    logic [6:0]  rx_flags = '0;
    logic [6:0]  tx_flags = '0;
    logic        init_det = 1'b0;
    logic        iq_mark = 1'b0;
    logic        cse_live = 1'b0;
    logic [5:0]  rssi_val = '0;
    logic        rssi_pulse = 1'b0;
    logic        rssi_adclk = 1'b0;
    logic [7:0]  sq1_word = '0;
    logic        sq1_strobe = 1'b0;
    logic [7:0]  sq2_word = '0;
    logic        sq2_strobe = 1'b0;
    logic [7:0]  corr_mag = '0;
    logic        corr_sclk = 1'b0;
    logic [18:0] freq_reg = '0;
    logic [7:0]  phase_reg = '0;
    logic [15:0] nco_reg = '0;
    logic        sym_clk = 1'b0;
    logic [7:0]  test_bus;
    logic        test_clk;

    integer n_checks = 0;
    integer n_errors = 0;
    bit     finished = 0;

    always #4 clk = ~clk;

    dbg_tbus_sel dut_i (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .adc_fullscale(adc_fullscale), .rx_flags(rx_flags), .tx_flags(tx_flags),
        .init_det(init_det), .iq_mark(iq_mark), .cse_live(cse_live),
        .rssi_val(rssi_val), .rssi_pulse(rssi_pulse), .rssi_adclk(rssi_adclk),
        .sq1_word(sq1_word), .sq1_strobe(sq1_strobe), .sq2_word(sq2_word),
        .sq2_strobe(sq2_strobe), .corr_mag(corr_mag), .corr_sclk(corr_sclk),
        .freq_reg(freq_reg), .phase_reg(phase_reg), .nco_reg(nco_reg),
        .sym_clk(sym_clk), .test_bus(test_bus), .test_clk(test_clk)
    );

    // Behavioural reference model, advanced on each rising edge.
    integer     m_view = 0;
    bit         m_lat = 0;
    bit         m_pprev = 0;
    bit         m_wrote = 0;
    logic [7:0] exp_bus = '0;
    logic       exp_clk = 1'b0;
    integer     exp_view = 0;
    string      exp_tag = "R1";

    function automatic string tag_of(input integer v);
        case (v)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 5: return "R6";
            6: return "R7";
            7, 8, 9: return "R8";
            0: return "R2";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_view = 0; m_lat = 0; m_pprev = 0; m_wrote = 0;
            exp_bus = 0; exp_clk = 0; exp_view = 0; exp_tag = "R1";
        end else begin
            exp_view = m_view;
            case (m_view)
                1: begin exp_bus = {adc_fullscale, rx_flags}; exp_clk = init_det; end
                2: begin exp_bus = {adc_fullscale, tx_flags}; exp_clk = iq_mark; end
                3: begin exp_bus = {m_lat, cse_live, rssi_val}; exp_clk = rssi_adclk; end
                4: begin exp_bus = sq1_word; exp_clk = sq1_strobe; end
                5: begin exp_bus = sq2_word; exp_clk = sq2_strobe; end
                6: begin exp_bus = corr_mag; exp_clk = corr_sclk; end
                7: begin exp_bus = 8'((freq_reg >> 11) & 19'hff); exp_clk = sym_clk; end
                8: begin exp_bus = phase_reg; exp_clk = sym_clk; end
                9: begin exp_bus = 8'(nco_reg / 256); exp_clk = sym_clk; end
                default: begin exp_bus = 0; exp_clk = 0; end
            endcase
            exp_tag = m_wrote ? "R11" : tag_of(m_view);
            m_wrote = addr_we;
            if (rssi_pulse && !m_pprev) m_lat = cse_live;
            m_pprev = rssi_pulse;
            if (addr_we) m_view = addr_wdata;
        end
    end

    task automatic check_now();
        n_checks++;
        if (test_bus !== exp_bus || test_clk !== exp_clk) begin
            n_errors++;
            $display("FAIL %s view=%0d: bus=%h clk=%b expected bus=%h clk=%b",
                     exp_tag, exp_view, test_bus, test_clk, exp_bus, exp_clk);
        end
        if (rst_n && exp_view == 3) begin
            n_checks++;
            if (test_bus[7] !== exp_bus[7]) begin
                n_errors++;
                $display("FAIL R10 latched bit: actual=%b expected=%b",
                         test_bus[7], exp_bus[7]);
            end
        end
    endtask

    task automatic drive_random();
        adc_fullscale = 1'($urandom); rx_flags = 7'($urandom); tx_flags = 7'($urandom);
        init_det = 1'($urandom); iq_mark = 1'($urandom); cse_live = 1'($urandom);
        rssi_val = 6'($urandom); rssi_pulse = (($urandom % 4) == 0);
        rssi_adclk = 1'($urandom); sq1_word = 8'($urandom); sq1_strobe = 1'($urandom);
        sq2_word = 8'($urandom); sq2_strobe = 1'($urandom); corr_mag = 8'($urandom);
        corr_sclk = 1'($urandom); freq_reg = 19'($urandom); phase_reg = 8'($urandom);
        nco_reg = 16'($urandom); sym_clk = 1'($urandom);
    endtask

    task automatic step(input bit we, input logic [7:0] wd);
        @(negedge clk);
        check_now();
        drive_random();
        addr_we = we;
        addr_wdata = wd;
    endtask

    initial begin
        logic [7:0] addrs [13];
        addrs = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                  8'h07, 8'h08, 8'h09, 8'h0A, 8'h7F, 8'hFF};
        // R1: outputs during and just after reset
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00);
        // Sweep every view, including out-of-range codes (R9)
        for (int a = 0; a < 13; a++) begin
            step(1'b1, addrs[a]);
            for (int c = 0; c < 40; c++) step(1'b0, 8'h00);
        end
        // Random rewrites so writes collide with RSSI pulse rises (R10, R11)
        for (int c = 0; c < 600; c++) begin
            bit w = (($urandom % 5) == 0);
            logic [7:0] wd = (($urandom % 3) == 0) ? 8'h03 : 8'($urandom % 12);
            step(w, wd);
        end
        step(1'b0, 8'h00);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule